// File: doc/BRIEF.md
# Paged PLL Divider Control Registers

This block holds the control state for a codec's clock generator. A serial control path delivers writes and reads that carry a 7-bit register address and 16-bit data. Three addresses are decoded. Two of them each hold one active-high power-down bit: one gates the internal clocks and one powers down the PLL. The third address is a paged window. A 3-bit page field in the write data picks one of eight 4-bit slots, and the write's low nibble is stored into that slot. Together the eight slots form a 22-bit fractional-N modulator word and a 7-bit clock division code.

Software builds the divider setting over eight writes to the paged address. The last write goes to page 7. That write copies the whole assembled word into a shadow register, and the shadow register drives the divider outputs. Because of this, the divider never sees a setting that is only half written. The PLL enable output is asserted only when both power-down bits are clear. The divider outputs are forced to zero whenever the PLL is not enabled.

Top module: `pll_pager_regs`

## Requirements
- R1: After reset, a read of 26h returns 16'h2000, a read of 3Ch returns 16'h0200 and a read of 46h returns 16'h0000. After reset, pll_enable, clk_gate_off being low is false (clk_gate_off is 1), div_code is 0 and frac_k is 0.
- R2: A write to 46h takes wr_data[6:4] as the page number and stores wr_data[3:0] into that page. The page number stays selected after the write. Bits wr_data[15:7] have no effect.
- R3: A read of 46h returns the selected page number in bits [6:4] and that page's stored nibble in bits [3:0]. Bits [15:7] read as 0.
- R4: The page map is as follows. Pages 0 to 4 hold frac_k[19:0], one nibble per page, with page 0 holding the lowest nibble. Page 5 holds frac_k[21:20] in bits [1:0]. Page 6 holds div_code[3:0]. Page 7 holds div_code[6:4] in bits [2:0]. Page 5 bits [3:2] and page 7 bit 3 always read as 0, and writes to them are ignored.
- R5: A write to page 7 loads the assembled word into the divider shadow register. While pll_enable is high, the new value appears on frac_k and div_code from the second rising edge after the write. It is not yet visible one edge after the write.
- R6: Writes to pages 0 to 6 leave frac_k and div_code unchanged.
- R7: Bit 13 of 26h is the internal clock-off bit and drives clk_gate_off. Bit 9 of 3Ch is the PLL power-down bit. All other bits of these two registers read as 0 and ignore writes.
- R8: pll_enable rises one clock after both power-down bits read 0. It falls in the same cycle in which either bit becomes 1.
- R9: While pll_enable is low, frac_k and div_code read as 0. While pll_enable is high, they show the shadow register.
- R10: A write to any address other than 26h, 3Ch or 46h changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 7 | Register address for read and write |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for reg_addr |
| div_code | output | 7 | Clock division code to the divider |
| frac_k | output | 22 | Fractional-N modulator word, unsigned fraction in steps of 1/2^22 |
| pll_enable | output | 1 | PLL enable |
| clk_gate_off | output | 1 | Internal clock disable, active high |

## Verification
The assertions assume that reg_addr, wr_data and wr_en change only away from the rising clock edge. They also assume that each write lasts exactly one cycle and that rst_n is released between edges. With those inputs, the PLL enable, the output zeroing and the shadow-update relations follow from register state alone. The bench drives every input on the falling edge and ends each write after one cycle. It samples the outputs on the falling edge, so the one-clock enable delay and the two-edge shadow delay are observed cycle by cycle.

// File: rtl/pll_pager_pkg.sv
package pll_pager_pkg;

  localparam int unsigned NIB_W = 4;

  // Number of valid bits that a field of the given width places in the slot.
  function automatic int unsigned slot_bits(int unsigned width, int unsigned slot);
    int unsigned base;
    base = slot * NIB_W;
    if (width <= base) return 0;
    else if (width - base >= NIB_W) return NIB_W;
    else return width - base;
  endfunction

  // Writable-bit mask of a page. The K pages come first, then the S pages.
  function automatic logic [NIB_W-1:0] nib_mask(int unsigned k_w, int unsigned s_w,
                                                int unsigned page);
    int unsigned kp;
    int unsigned n;
    kp = (k_w + NIB_W - 1) / NIB_W;
    n  = (page < kp) ? slot_bits(k_w, page) : slot_bits(s_w, page - kp);
    return NIB_W'((1 << n) - 1);
  endfunction

  // PLL may run only when both power-down bits are clear.
  function automatic logic pd_both_low(logic clk_off, logic pll_pd);
    return !clk_off && !pll_pd;
  endfunction

endpackage

// File: rtl/pll_page_file.sv
module pll_page_file
  import pll_pager_pkg::*;
#(
  parameter int unsigned PAGE_SEL_W = 3,
  parameter int unsigned K_W        = 22,
  parameter int unsigned S_W        = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [PAGE_SEL_W-1:0] wr_page,
  input  logic [NIB_W-1:0]      wr_nib,
  output logic [PAGE_SEL_W-1:0] sel_page,
  output logic [NIB_W-1:0]      sel_nib,
  output logic [K_W-1:0]        k_word,
  output logic [S_W-1:0]        s_word
);

  localparam int unsigned NUM_PAGES = 1 << PAGE_SEL_W;
  localparam int unsigned K_PAGES   = (K_W + NIB_W - 1) / NIB_W;
  localparam int unsigned S_LSB     = K_PAGES * NIB_W;

  logic [NUM_PAGES-1:0][NIB_W-1:0] pg_q;
  logic [PAGE_SEL_W-1:0]           sel_q;
  logic [NUM_PAGES*NIB_W-1:0]      flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= '0;
      sel_q <= '0;
    end else if (wr_stb) begin
      sel_q <= wr_page;
      for (int p = 0; p < int'(NUM_PAGES); p++) begin
        if (wr_page == PAGE_SEL_W'(p))
          pg_q[p] <= wr_nib & nib_mask(K_W, S_W, p);
      end
    end
  end

  assign flat     = pg_q;
  assign k_word   = flat[K_W-1:0];
  assign s_word   = flat[S_LSB +: S_W];
  assign sel_page = sel_q;
  assign sel_nib  = pg_q[sel_q];

endmodule

// File: rtl/pll_word_shadow.sv
module pll_word_shadow #(
  parameter int unsigned K_W = 22,
  parameter int unsigned S_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic [K_W-1:0] k_in,
  input  logic [S_W-1:0] s_in,
  output logic [K_W-1:0] k_out,
  output logic [S_W-1:0] s_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_out <= '0;
      s_out <= '0;
    end else if (commit) begin
      k_out <= k_in;
      s_out <= s_in;
    end
  end

endmodule

// File: rtl/pll_pd_ctrl.sv
module pll_pd_ctrl
  import pll_pager_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_clk_reg,
  input  logic wr_pll_reg,
  input  logic clk_off_d,
  input  logic pll_pd_d,
  output logic clk_off_q,
  output logic pll_pd_q,
  output logic pll_enable
);

  logic en_q;
  logic both_low;

  assign both_low = pd_both_low(clk_off_q, pll_pd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_off_q <= 1'b1;
      pll_pd_q  <= 1'b1;
      en_q      <= 1'b0;
    end else begin
      if (wr_clk_reg) clk_off_q <= clk_off_d;
      if (wr_pll_reg) pll_pd_q  <= pll_pd_d;
      en_q <= both_low;
    end
  end

  // Rises one clock after both bits are low; drops as soon as a bit is set.
  assign pll_enable = en_q && both_low;

endmodule

// File: rtl/pll_pager_regs.sv
module pll_pager_regs
  import pll_pager_pkg::*;
#(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PAGE_SEL_W   = 3,
  parameter int unsigned PAGE_LSB     = 4,
  parameter int unsigned K_W          = 22,
  parameter int unsigned S_W          = 7,
  parameter int unsigned CLK_OFF_BIT  = 13,
  parameter int unsigned PLL_PD_BIT   = 9,
  parameter logic [ADDR_W-1:0] CLK_REG_ADDR  = 7'h26,
  parameter logic [ADDR_W-1:0] PLL_REG_ADDR  = 7'h3C,
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 7'h46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [S_W-1:0]    div_code,
  output logic [K_W-1:0]    frac_k,
  output logic              pll_enable,
  output logic              clk_gate_off
);

  localparam logic [PAGE_SEL_W-1:0] LAST_PAGE = '1;

  // Decoded write strobes
  logic wr_clk_reg, wr_pll_reg, wr_page_reg;
  assign wr_clk_reg  = wr_en && (reg_addr == CLK_REG_ADDR);
  assign wr_pll_reg  = wr_en && (reg_addr == PLL_REG_ADDR);
  assign wr_page_reg = wr_en && (reg_addr == PAGE_REG_ADDR);

  logic [PAGE_SEL_W-1:0] wr_page;
  logic [NIB_W-1:0]      wr_nib;
  assign wr_page = wr_data[PAGE_LSB +: PAGE_SEL_W];
  assign wr_nib  = wr_data[NIB_W-1:0];

  // Named internal events for the checker
  logic                  commit_q;
  logic [PAGE_SEL_W-1:0] sel_page;
  logic [NIB_W-1:0]      sel_nib;
  logic [K_W-1:0]        k_stage;
  logic [S_W-1:0]        s_stage;
  logic [K_W-1:0]        k_shadow;
  logic [S_W-1:0]        s_shadow;
  logic                  clk_off_q, pll_pd_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  pll_page_file #(
    .PAGE_SEL_W(PAGE_SEL_W), .K_W(K_W), .S_W(S_W)
  ) u_pages (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_page_reg), .wr_page(wr_page), .wr_nib(wr_nib),
    .sel_page(sel_page), .sel_nib(sel_nib),
    .k_word(k_stage), .s_word(s_stage)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= wr_page_reg && (wr_page == LAST_PAGE);
  end

  pll_word_shadow #(.K_W(K_W), .S_W(S_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .commit(commit_q),
    .k_in(k_stage), .s_in(s_stage),
    .k_out(k_shadow), .s_out(s_shadow)
  );

  pll_pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n),
    .wr_clk_reg(wr_clk_reg), .wr_pll_reg(wr_pll_reg),
    .clk_off_d(wr_data[CLK_OFF_BIT]), .pll_pd_d(wr_data[PLL_PD_BIT]),
    .clk_off_q(clk_off_q), .pll_pd_q(pll_pd_q),
    .pll_enable(pll_enable)
  );

  assign clk_gate_off = clk_off_q;
  assign div_code     = pll_enable ? s_shadow : '0;
  assign frac_k       = pll_enable ? k_shadow : '0;

  always_comb begin
    rd_data = '0;
    if (reg_addr == CLK_REG_ADDR) begin
      rd_data[CLK_OFF_BIT] = clk_off_q;
    end else if (reg_addr == PLL_REG_ADDR) begin
      rd_data[PLL_PD_BIT] = pll_pd_q;
    end else if (reg_addr == PAGE_REG_ADDR) begin
      rd_data[PAGE_LSB +: PAGE_SEL_W] = sel_page;
      rd_data[NIB_W-1:0]              = sel_nib;
    end
  end

endmodule

// File: rtl/pll_pager_chk.sv
module pll_pager_chk #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_SEL_W = 3,
  parameter int unsigned PAGE_LSB   = 4,
  parameter int unsigned K_W        = 22,
  parameter int unsigned S_W        = 7,
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 7'h46
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pll_enable,
  input logic                  clk_off,
  input logic                  pll_pd,
  input logic                  commit,
  input logic [K_W-1:0]        k_sh,
  input logic [S_W-1:0]        s_sh,
  input logic [K_W-1:0]        frac_k,
  input logic [S_W-1:0]        div_code,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     rd_data,
  input logic [PAGE_SEL_W-1:0] sel_page
);

  localparam int unsigned HI_LSB = PAGE_LSB + PAGE_SEL_W;

  // R8
  pll_on_needs_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_enable |-> (!clk_off && !pll_pd));

  // R8
  pll_rise_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_enable) |-> $past(!clk_off && !pll_pd));

  // R9
  div_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_enable |-> (frac_k == '0 && div_code == '0));

  // R5
  shadow_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({k_sh, s_sh}) |-> $past(commit));

  // R3
  page_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == PAGE_REG_ADDR) |-> ((rd_data >> HI_LSB) == '0));

  // R3
  page_read_selector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == PAGE_REG_ADDR) |-> (rd_data[PAGE_LSB +: PAGE_SEL_W] == sel_page));

endmodule

bind pll_pager_regs pll_pager_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SEL_W(PAGE_SEL_W), .PAGE_LSB(PAGE_LSB),
  .K_W(K_W), .S_W(S_W), .PAGE_REG_ADDR(PAGE_REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_enable(pll_enable),
  .clk_off(clk_off_q), .pll_pd(pll_pd_q), .commit(commit_q),
  .k_sh(k_shadow), .s_sh(s_shadow), .frac_k(frac_k), .div_code(div_code),
  .reg_addr(reg_addr), .rd_data(rd_data), .sel_page(sel_page)
);

// File: tb/test_pll_pager_regs.sv
module test_pll_pager_regs;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [6:0]  div_code;
  logic [21:0] frac_k;
  logic        pll_enable;
  logic        clk_gate_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_pager_regs i_pll_pager_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .div_code(div_code),
    .frac_k(frac_k), .pll_enable(pll_enable), .clk_gate_off(clk_gate_off)
  );

  // {page, nibble written, nibble expected on read-back}
  localparam logic [10:0] VEC [10] = '{
    {3'd0, 4'h9, 4'h9}, {3'd1, 4'hF, 4'hF}, {3'd2, 4'h6, 4'h6},
    {3'd3, 4'hF, 4'hF}, {3'd4, 4'h1, 4'h1}, {3'd5, 4'hF, 4'h3},
    {3'd6, 4'hC, 4'hC}, {3'd7, 4'hF, 4'h7}, {3'd5, 4'h6, 4'h2},
    {3'd7, 4'h8, 4'h0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; reg_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Ends at the falling edge right after the writing edge.
  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [15:0] page_wd(logic [2:0] p, logic [3:0] n);
    return {9'h000, p, n};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    do_reset();

    // Table walk: R2, R3, R4
    foreach (VEC[i]) begin
      wr(7'h46, page_wd(VEC[i][10:8], VEC[i][7:4]));
      rd(7'h46, r);
      chk($sformatf("R4 page %0d readback", VEC[i][10:8]), 32'(r),
          32'(page_wd(VEC[i][10:8], VEC[i][3:0])));
    end

    do_reset();
    // R1
    rd(7'h26, r); chk("R1 26h reset", 32'(r), 32'h2000);
    rd(7'h3C, r); chk("R1 3Ch reset", 32'(r), 32'h0200);
    rd(7'h46, r); chk("R1 46h reset", 32'(r), 32'h0000);
    chk("R1 pll_enable reset", 32'(pll_enable), 0);
    chk("R1 clk_gate_off reset", 32'(clk_gate_off), 1);
    chk("R1 frac_k reset", 32'(frac_k), 0);
    chk("R1 div_code reset", 32'(div_code), 0);

    // R8: enable after both bits cleared
    wr(7'h26, 16'h0000);
    chk("R7 clk_gate_off cleared", 32'(clk_gate_off), 0);
    chk("R8 one bit still set", 32'(pll_enable), 0);
    wr(7'h3C, 16'h0000);
    chk("R8 not yet enabled", 32'(pll_enable), 0);
    @(negedge clk);
    chk("R8 enabled one clock later", 32'(pll_enable), 1);

    // R6 / R5: build K=2ABCDE, S=5A
    wr(7'h46, page_wd(3'd0, 4'hE));
    wr(7'h46, page_wd(3'd1, 4'hD));
    wr(7'h46, page_wd(3'd2, 4'hC));
    wr(7'h46, page_wd(3'd3, 4'hB));
    wr(7'h46, page_wd(3'd4, 4'hA));
    wr(7'h46, page_wd(3'd5, 4'h2));
    wr(7'h46, page_wd(3'd6, 4'hA));
    @(negedge clk);
    chk("R6 frac_k before page 7", 32'(frac_k), 0);
    chk("R6 div_code before page 7", 32'(div_code), 0);
    wr(7'h46, page_wd(3'd7, 4'h5));
    chk("R5 not visible one edge after", 32'(frac_k), 0);
    @(negedge clk);
    chk("R5 frac_k committed", 32'(frac_k), 32'h2ABCDE);
    chk("R5 div_code committed", 32'(div_code), 32'h5A);

    wr(7'h46, page_wd(3'd0, 4'h0));
    repeat (2) @(negedge clk);
    chk("R6 page 0 rewrite held", 32'(frac_k), 32'h2ABCDE);

    // R2: upper data bits ignored
    wr(7'h46, 16'hFF93);
    rd(7'h46, r); chk("R2 upper bits ignored", 32'(r), 32'h0013);

    // R10: other address
    wr(7'h20, 16'hFFFF);
    rd(7'h26, r); chk("R10 26h untouched", 32'(r), 0);
    rd(7'h3C, r); chk("R10 3Ch untouched", 32'(r), 0);
    rd(7'h46, r); chk("R10 46h untouched", 32'(r), 32'h0013);
    rd(7'h20, r); chk("R10 other reads 0", 32'(r), 0);
    chk("R10 pll still on", 32'(pll_enable), 1);

    // R7: only the defined bits stick
    wr(7'h26, 16'hDFFF);
    rd(7'h26, r); chk("R7 26h other bits", 32'(r), 0);
    wr(7'h3C, 16'hFDFF);
    rd(7'h3C, r); chk("R7 3Ch other bits", 32'(r), 0);

    // R8 / R9: power down the PLL
    wr(7'h3C, 16'h0200);
    chk("R8 drop same cycle", 32'(pll_enable), 0);
    chk("R9 frac_k zeroed", 32'(frac_k), 0);
    chk("R9 div_code zeroed", 32'(div_code), 0);
    rd(7'h3C, r); chk("R7 3Ch readback", 32'(r), 32'h0200);
    wr(7'h3C, 16'h0000);
    chk("R8 re-enable delayed", 32'(pll_enable), 0);
    @(negedge clk);
    chk("R8 re-enabled", 32'(pll_enable), 1);
    chk("R9 shadow shown again", 32'(frac_k), 32'h2ABCDE);

    wr(7'h26, 16'h2000);
    chk("R8 clock-off drops enable", 32'(pll_enable), 0);
    chk("R7 clk_gate_off set", 32'(clk_gate_off), 1);
    rd(7'h26, r); chk("R7 26h readback", 32'(r), 32'h2000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule